// File: doc/BRIEF.md
# Accumulation Interval Controller

This block sets the length of an energy accumulation interval from the stream of per-sample ticks produced by the converter's input multiplexer. A configuration byte holds two fields. A 2-bit code selects how many samples make up one inner cycle. A 6-bit count sets how many of those cycles make up one interval. The interval length in samples is the product of the two. Several field pairs therefore give the same interval, for example 42 x 50 and 100 x 21 both give 2100 samples.

The first tick after reset opens an interval, and so does the first tick after an interval ends. The configuration is captured on that opening tick. When the last sample of the interval arrives, the block pulses an end marker and a one-clock latch enable for the accumulator registers. It also sets a sticky ready flag for the processor. If an interval ends while that flag is still set, a sticky overrun bit records the loss.

Top module: `accum_window_ctrl`

## Requirements
- R1: Code bits [7:6] of `cfg_word` select the samples per inner cycle: code 0 gives 42, code 1 gives 50, code 2 gives 84 and code 3 gives 100.
- R2: Bits [5:0] of `cfg_word` give the number of inner cycles per interval, and a value of 0 means 64 cycles.
- R3: An interval spans exactly (samples per cycle) x (cycles) ticks. `win_end` is high for one clock, in the clock after the edge that sampled the interval's last tick.
- R4: `win_start` is high for one clock, in the clock after the edge that sampled an opening tick. An opening tick is the first tick after reset or the first tick after an interval ended.
- R5: `cfg_word` is sampled only on an opening tick. Changes made while an interval runs do not alter that interval's length.
- R6: `capture_en` is high for exactly one clock at each interval end, in the same clock as `win_end`.
- R7: `ready_irq` is set in the clock that `win_end` is high and stays set until `ack_clr` is sampled high. If an end and a clear are sampled in the same clock, the flag stays set.
- R8: `ready_ovr` is set when an interval ends while `ready_irq` is set and `ack_clr` is low. It stays set until `ack_clr` is sampled high.
- R9: While `rst_n` is low, all outputs are 0.
- R10: Clocks without a tick do not advance the interval. Ticks may be spaced by any number of idle clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | One-clock pulse per converted sample |
| cfg_word | input | 8 | Cycle-size code [7:6] and cycle count [5:0] |
| ack_clr | input | 1 | Clears the ready flag and the overrun bit |
| win_start | output | 1 | Pulse after the opening tick of an interval |
| win_end | output | 1 | Pulse after the closing tick of an interval |
| capture_en | output | 1 | One-clock latch enable for the accumulated values |
| ready_irq | output | 1 | Sticky data-ready interrupt flag |
| ready_ovr | output | 1 | Sticky overrun bit |

## Verification
The assertions assume that `tick_in` is a clean, synchronous signal. Because every code gives at least two samples per cycle, they also assume that no interval can open and close on the same tick. Neither assumption constrains `ack_clr`. The stimulus drives ticks and clears only on falling clock edges. It uses dense and sparse tick spacing, and it issues clears on their own and on the same clock as a closing tick. `cfg_word` changes both between intervals and inside a running interval.

// File: rtl/accwin_pkg.sv
package accwin_pkg;
   localparam int CODE_W  = 2;
   localparam int CYC_W   = 6;
   localparam int INNER_W = 7;
   localparam int CFG_W   = CODE_W + CYC_W;
   localparam int NCODES  = 2 ** CODE_W;

   typedef struct packed {
      logic [INNER_W-1:0] per_cycle;
      logic [CYC_W:0]     cycles;
   } win_cfg_t;
endpackage

// File: rtl/accwin_cfg_decode.sv
module accwin_cfg_decode #(
   parameter int CODE_W  = 2,
   parameter int CYC_W   = 6,
   parameter int INNER_W = 7,
   parameter logic [(2**CODE_W)*INNER_W-1:0] INNER_TABLE = {7'd100, 7'd84, 7'd50, 7'd42}
) (
   input  logic [CODE_W+CYC_W-1:0] cfg_word,
   output logic [INNER_W-1:0]      per_cycle,
   output logic [CYC_W:0]          cycles
);
   localparam int NCODES = 2 ** CODE_W;
   localparam int TOP    = CODE_W + CYC_W - 1;

   logic [INNER_W-1:0] lut [NCODES];
   logic [CODE_W-1:0]  code;
   logic [CYC_W-1:0]   field;

   for (genvar g = 0; g < NCODES; g++) begin : g_lut
      assign lut[g] = INNER_TABLE[g*INNER_W +: INNER_W];
      if (INNER_TABLE[g*INNER_W +: INNER_W] < 2) begin : g_bad
         initial $fatal(1, "inner cycle size below 2 at code %0d", g);
      end
   end

   assign code  = cfg_word[TOP -: CODE_W];
   assign field = cfg_word[CYC_W-1:0];

   always_comb begin
      per_cycle = lut[code];
      if (field == '0) cycles = {1'b1, {CYC_W{1'b0}}};
      else             cycles = {1'b0, field};
   end
endmodule

// File: rtl/accwin_counter.sv
module accwin_counter #(
   parameter int INNER_W = 7,
   parameter int CYC_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [INNER_W-1:0] new_per_cycle,
   input  logic [CYC_W:0]     new_cycles,
   output logic               opening,
   output logic               closing
);
   logic               at_open;
   logic [INNER_W-1:0] inner_q, lim_in;
   logic [CYC_W:0]     outer_q, lim_out;
   logic               inner_wrap, outer_last;

   assign inner_wrap = (inner_q == INNER_W'(lim_in - 1'b1));
   assign outer_last = (outer_q == (CYC_W+1)'(lim_out - 1'b1));
   assign opening    = tick && at_open;
   assign closing    = tick && !at_open && inner_wrap && outer_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         at_open <= 1'b1;
         inner_q <= '0;
         outer_q <= '0;
         lim_in  <= '0;
         lim_out <= '0;
      end else if (opening) begin
         lim_in  <= new_per_cycle;
         lim_out <= new_cycles;
         inner_q <= INNER_W'(1);
         outer_q <= '0;
         at_open <= 1'b0;
      end else if (tick) begin
         if (closing) at_open <= 1'b1;
         if (inner_wrap) begin
            inner_q <= '0;
            outer_q <= outer_q + 1'b1;
         end else begin
            inner_q <= inner_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/accwin_flag.sv
module accwin_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_evt,
   input  logic clr,
   output logic flag,
   output logic ovr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
         ovr  <= 1'b0;
      end else begin
         if (set_evt)  flag <= 1'b1;
         else if (clr) flag <= 1'b0;
         if (set_evt && flag && !clr) ovr <= 1'b1;
         else if (clr)                ovr <= 1'b0;
      end
   end
endmodule

// File: rtl/accum_window_ctrl.sv
module accum_window_ctrl #(
   parameter int CODE_W  = accwin_pkg::CODE_W,
   parameter int CYC_W   = accwin_pkg::CYC_W,
   parameter int INNER_W = accwin_pkg::INNER_W,
   parameter logic [(2**CODE_W)*INNER_W-1:0] INNER_TABLE = {7'd100, 7'd84, 7'd50, 7'd42}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick_in,
   input  logic [CODE_W+CYC_W-1:0]  cfg_word,
   input  logic                     ack_clr,
   output logic                     win_start,
   output logic                     win_end,
   output logic                     capture_en,
   output logic                     ready_irq,
   output logic                     ready_ovr
);
   initial begin
      assert (CODE_W >= 1 && CYC_W >= 1) else $fatal(1, "field widths must be positive");
      assert (INNER_W >= 2) else $fatal(1, "inner width too small");
   end

   logic [INNER_W-1:0] dec_per_cycle;
   logic [CYC_W:0]     dec_cycles;
   logic               opening, closing;

   accwin_cfg_decode #(
      .CODE_W(CODE_W), .CYC_W(CYC_W), .INNER_W(INNER_W), .INNER_TABLE(INNER_TABLE)
   ) i_dec (
      .cfg_word (cfg_word),
      .per_cycle(dec_per_cycle),
      .cycles   (dec_cycles)
   );

   accwin_counter #(.INNER_W(INNER_W), .CYC_W(CYC_W)) i_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick_in),
      .new_per_cycle(dec_per_cycle),
      .new_cycles   (dec_cycles),
      .opening      (opening),
      .closing      (closing)
   );

   accwin_flag i_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_evt(closing),
      .clr    (ack_clr),
      .flag   (ready_irq),
      .ovr    (ready_ovr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_start  <= 1'b0;
         win_end    <= 1'b0;
         capture_en <= 1'b0;
      end else begin
         win_start  <= opening;
         win_end    <= closing;
         capture_en <= closing;
      end
   end
endmodule

// File: rtl/accum_window_chk.sv
module accum_window_chk (
   input logic clk,
   input logic rst_n,
   input logic tick_in,
   input logic ack_clr,
   input logic win_start,
   input logic win_end,
   input logic capture_en,
   input logic ready_irq,
   input logic ready_ovr
);
   // R6
   capture_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      capture_en |=> !capture_en);
   // R7
   end_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |-> ready_irq);
   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_irq) |-> $past(ack_clr));
   // R8
   ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_ovr) |-> (win_end && $past(ready_irq)));
   // R10
   no_tick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick_in) |-> !(win_start || win_end));
   // R4
   start_end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(win_start && win_end));
endmodule

bind accum_window_ctrl accum_window_chk i_chk (.*);

// File: tb/test_accum_window_ctrl.sv
module test_accum_window_ctrl;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_in = 1'b0;
   logic [7:0] cfg_word = 8'h00;
   logic ack_clr = 1'b0;
   logic win_start, win_end, capture_en, ready_irq, ready_ovr;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   accum_window_ctrl i_accum_window_ctrl (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .cfg_word(cfg_word),
      .ack_clr(ack_clr), .win_start(win_start), .win_end(win_end),
      .capture_en(capture_en), .ready_irq(ready_irq), .ready_ovr(ready_ovr)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int size_of(input logic [1:0] c);
      case (c)
         2'd0: return 42;
         2'd1: return 50;
         2'd2: return 84;
         default: return 100;
      endcase
   endfunction

   // reference model
   bit m_open = 1'b1;
   int m_cnt = 0, m_target = 0;
   bit m_start = 0, m_end = 0, m_irq = 0, m_ovr = 0;

   always @(posedge clk) begin
      bit irq_old;
      if (!rst_n) begin
         m_open = 1; m_cnt = 0; m_target = 0;
         m_start = 0; m_end = 0; m_irq = 0; m_ovr = 0;
      end else begin
         m_start = 0; m_end = 0;
         if (tick_in) begin
            if (m_open) begin
               m_target = size_of(cfg_word[7:6]) *
                          ((cfg_word[5:0] == 0) ? 64 : int'(cfg_word[5:0]));
               m_cnt = 1; m_open = 0; m_start = 1;
            end else begin
               m_cnt++;
               if (m_cnt == m_target) begin
                  m_end = 1; m_open = 1;
               end
            end
         end
         irq_old = m_irq;
         if (m_end && irq_old && !ack_clr) m_ovr = 1;
         else if (ack_clr) m_ovr = 0;
         if (m_end) m_irq = 1;
         else if (ack_clr) m_irq = 0;
      end
   end

   always @(negedge clk) if (!done) begin
      chk(win_start == m_start, "R4 win_start", int'(win_start), int'(m_start));
      chk(win_end == m_end, "R3 win_end", int'(win_end), int'(m_end));
      chk(capture_en == m_end, "R6 capture_en", int'(capture_en), int'(m_end));
      chk(ready_irq == m_irq, "R7 ready_irq", int'(ready_irq), int'(m_irq));
      chk(ready_ovr == m_ovr, "R8 ready_ovr", int'(ready_ovr), int'(m_ovr));
   end

   // runs one interval; returns the number of ticks until win_end
   task automatic run_iv(input logic [7:0] cfg, input int gap, input int chg_at,
                         input logic [7:0] chg_cfg, input int clr_at, output int n);
      cfg_word = cfg;
      n = 0;
      do begin
         tick_in = 1'b1;
         ack_clr = (n + 1 == clr_at);
         @(negedge clk);
         tick_in = 1'b0;
         ack_clr = 1'b0;
         n++;
         if (n == chg_at) cfg_word = chg_cfg;
         if (!win_end) repeat (gap) @(negedge clk);
      end while (!win_end && n < 7000);
   endtask

   task automatic pulse_clr();
      ack_clr = 1'b1;
      @(negedge clk);
      ack_clr = 1'b0;
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R9 reset state
      chk({win_start, win_end, capture_en, ready_irq, ready_ovr} == 5'b0,
          "R9 reset outputs", int'({win_start, win_end, capture_en, ready_irq, ready_ovr}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 each code, one cycle
      run_iv(8'h01, 0, 0, 8'h00, 0, n); chk(n == 42,  "R1 code0", n, 42);
      run_iv(8'h41, 0, 0, 8'h00, 0, n); chk(n == 50,  "R1 code1", n, 50);
      run_iv(8'h81, 0, 0, 8'h00, 0, n); chk(n == 84,  "R1 code2", n, 84);
      run_iv(8'hC1, 0, 0, 8'h00, 0, n); chk(n == 100, "R1 code3", n, 100);
      // R8 overrun built up from intervals above
      chk(ready_ovr == 1'b1, "R8 overrun set", int'(ready_ovr), 1);
      pulse_clr();
      chk({ready_irq, ready_ovr} == 2'b00, "R7 clear", int'({ready_irq, ready_ovr}), 0);

      // R3 product, R2 zero means 64
      run_iv(8'h02, 0, 0, 8'h00, 0, n); chk(n == 84,   "R3 product 42x2", n, 84);
      run_iv(8'h00, 0, 0, 8'h00, 0, n); chk(n == 2688, "R2 zero as 64", n, 2688);
      // R10 sparse ticks
      run_iv(8'h43, 3, 0, 8'h00, 0, n); chk(n == 150,  "R10 sparse ticks", n, 150);
      // R5 mid-interval change ignored
      run_iv(8'h01, 0, 5, 8'hC5, 0, n); chk(n == 42,   "R5 mid change", n, 42);
      pulse_clr();
      repeat (4) @(negedge clk);
      chk(win_start == 1'b0 && win_end == 1'b0, "R10 idle quiet", int'(win_end), 0);

      // R7 flag holds until clear
      run_iv(8'h41, 0, 0, 8'h00, 0, n);
      repeat (10) @(negedge clk);
      chk(ready_irq == 1'b1, "R7 sticky", int'(ready_irq), 1);
      // R7/R8 clear on the closing tick: flag stays, no overrun
      run_iv(8'h41, 0, 0, 8'h00, 50, n);
      chk(ready_irq == 1'b1, "R7 set wins", int'(ready_irq), 1);
      chk(ready_ovr == 1'b0, "R8 no overrun with clear", int'(ready_ovr), 0);
      pulse_clr();
      chk({ready_irq, ready_ovr} == 2'b00, "R7 final clear", int'({ready_irq, ready_ovr}), 0);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end
endmodule